// File: doc/BRIEF.md
# Processor Tick Timer Unit

This block is a per-core tick timer. It holds a 32-bit count register and a control word that carries an operating mode, an interrupt enable, an interrupt pending flag and a 28-bit period target. While counting is enabled, the count register advances by one on every cycle in which the prescaler's tick enable is high. A match occurs on the tick that brings the low 28 bits of the count to the period target; the upper count bits take no part in the compare. On a match the timer can flag an interrupt, and then clears the count, stops, or keeps counting, as the mode selects.

Software reaches both registers through a simple synchronous port with select, write enable, address, write data and registered read data. A small state machine tracks whether the timer is counting. It has three states. S_IDLE means stopped by mode 00 or by reset. S_RUN means counting. S_HALT means stopped after a single-shot match. The transitions are:
- T_START: from S_IDLE or S_HALT to S_RUN, on a control write with a nonzero mode.
- T_STOP: from S_RUN or S_HALT to S_IDLE, on a control write with mode 00.
- T_SHOT: from S_RUN to S_HALT, on a match in single-shot mode with no control write in that cycle.

A control write in the same cycle as a match takes T_START or T_STOP instead of T_SHOT. The level interrupt output is the pending flag gated by the enable.

Top module: `tick_timer`

## Requirements
- R1: After reset the control word and the count read 0, irq is low and the timer is in S_IDLE, so ticks leave the count at 0.
- R2: Address 0 is the control word and address 1 is the count. The control word holds the mode in bits [31:30] (00 disabled, 01 restart, 10 single-shot, 11 continuous), the interrupt enable in bit 29, the pending flag in bit 28 and the period in bits [27:0]. A read (sel=1, we=0) returns the addressed register's value from before that clock edge, and rdata carries it from the cycle after. The count takes any written value and reads it back. While counting, it rises by one per cycle with tick_en=1, and it holds otherwise.
- R3: A match is the counting tick after which count[27:0] equals the period. Count bits [31:28] are ignored in the compare and keep counting.
- R4: If the period is not above the current count[27:0], the next match comes only after count[27:0] wraps through 0 and climbs back to the period.
- R5: A match while bit 29 is 1 sets the pending bit 28. A match while bit 29 is 0 leaves bit 28 unchanged. irq is high exactly when bits 28 and 29 are both 1.
- R6: A control write with bit 28 = 0 clears pending. If a match with the enable set falls in the same cycle as that write, pending stays set.
- R7: In restart mode (01) a match clears the count to 0, and counting continues from 0.
- R8: In single-shot mode (10) a match stops counting. The count holds the matched value through later ticks until a control write with a nonzero mode restarts counting.
- R9: In continuous mode (11) the count keeps rising through a match without being cleared.
- R10: A control write with mode 00 stops counting. Later ticks change neither the count nor pending.
- R11: A count write in the same cycle as a tick leaves the written value in the count. There is no increment and no match in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Register access strobe |
| we | input | 1 | Write (1) or read (0) when sel is high |
| addr | input | 1 | 0 = control word, 1 = count |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| tick_en | input | 1 | Prescaler tick, one count step per high cycle |
| irq | output | 1 | Level timer interrupt |

## Verification
The bench sets the count just below the 28-bit boundary with a period of 1. This checks that the compare masks the upper bits and waits out the wrap; a design comparing all 32 bits would never match there. It also collides a pending-clear write with a matching tick, and a count write with a tick. A design that put the write first would lose the interrupt in the first case, and in the second it would show the count one step high. Single-shot is checked for holding through extra ticks and for restarting on a rewrite. Restart mode is checked for landing on 0 rather than on the period value. A wrong design would stay in S_HALT, or show an off-by-one period.

// File: rtl/tt_pkg.sv
package tt_pkg;
    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        M_OFF     = 2'b00,
        M_RESTART = 2'b01,
        M_SHOT    = 2'b10,
        M_CONT    = 2'b11
    } tt_mode_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'b00,
        S_RUN  = 2'b01,
        S_HALT = 2'b10
    } tt_state_e;
endpackage

// File: rtl/tt_fsm.sv
module tt_fsm
    import tt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     mode_wr,
    input  tt_mode_e wr_mode,
    input  tt_mode_e cur_mode,
    input  logic     match,
    output logic     run
);
    tt_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (mode_wr) begin
            state_d = (wr_mode != M_OFF) ? S_RUN : S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:  state_d = S_IDLE;
                S_RUN:   if (match && cur_mode == M_SHOT) state_d = S_HALT;
                S_HALT:  state_d = S_HALT;
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        run = (state_q == S_RUN);
    end

    // R8
    shot_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && match && cur_mode == M_SHOT && !mode_wr) |=> !run);

    // R10
    off_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && wr_mode == M_OFF) |=> !run);
endmodule

// File: rtl/tt_count.sv
module tt_count #(
    parameter int CNT_W = 32,
    parameter int PER_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic [PER_W-1:0] period,
    input  logic             clr_on_match,
    output logic [CNT_W-1:0] count,
    output logic             match
);
    logic [CNT_W-1:0] count_q, count_d, stepped;

    always_comb begin
        stepped = count_q + 1'b1;
        match   = run && tick && !wr && (stepped[PER_W-1:0] == period);
        count_d = count_q;
        if (wr)                        count_d = wdata;
        else if (match && clr_on_match) count_d = '0;
        else if (run && tick)          count_d = stepped;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr) |=> $stable(count_q));

    // R7
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && clr_on_match) |=> (count_q == '0));

    // R11
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (count_q == $past(wdata)));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tt_pkg::*;
#(
    parameter int DATA_W = REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tick_en,
    output logic              irq
);
    localparam int PER_W  = DATA_W - 4;
    localparam int IP_BIT = DATA_W - 4;
    localparam int IE_BIT = DATA_W - 3;

    tt_mode_e          mode_q;
    logic              ie_q, ip_q;
    logic [PER_W-1:0]  period_q;
    logic [DATA_W-1:0] rdata_q, ctrl_word, count;
    logic              mode_wr, cnt_wr, match, run, ip_set;
    tt_mode_e          wr_mode;

    assign mode_wr = sel && we && !addr;
    assign cnt_wr  = sel && we && addr;
    assign wr_mode = tt_mode_e'(wdata[DATA_W-1 -: 2]);
    assign ip_set  = match && ie_q;

    tt_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_wr  (mode_wr),
        .wr_mode  (wr_mode),
        .cur_mode (mode_q),
        .match    (match),
        .run      (run)
    );

    tt_count #(.CNT_W(DATA_W), .PER_W(PER_W)) u_count (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run),
        .tick         (tick_en),
        .wr           (cnt_wr),
        .wdata        (wdata),
        .period       (period_q),
        .clr_on_match (mode_q == M_RESTART),
        .count        (count),
        .match        (match)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= M_OFF;
            ie_q     <= 1'b0;
            ip_q     <= 1'b0;
            period_q <= '0;
        end else begin
            if (mode_wr) begin
                mode_q   <= wr_mode;
                ie_q     <= wdata[IE_BIT];
                period_q <= wdata[PER_W-1:0];
            end
            ip_q <= (mode_wr ? wdata[IP_BIT] : ip_q) | ip_set;
        end
    end

    assign ctrl_word = {mode_q, ie_q, ip_q, period_q};

    always_ff @(posedge clk) begin
        if (!rst_n)          rdata_q <= '0;
        else if (sel && !we) rdata_q <= addr ? count : ctrl_word;
    end

    always_comb begin
        rdata = rdata_q;
        irq   = ip_q && ie_q;
    end

    // R5
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ip_set |=> ip_q);

    // R5
    pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ip_q) |-> $past(match || mode_wr));

    // R6
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !wdata[IP_BIT] && !ip_set) |=> !ip_q);
endmodule

// File: tb/tick_timer_test.sv
module tick_timer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        sel = 0, we = 0, addr = 0, tick_en = 0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          n_run = 0, n_fail = 0;
    logic [31:0] v;

    tick_timer uut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick_en(tick_en), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 20000);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [31:0] d);
        @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
        @(negedge clk); sel = 0; we = 0;
    endtask

    task automatic rd(logic a, output logic [31:0] d);
        @(negedge clk); sel = 1; we = 0; addr = a;
        @(negedge clk); sel = 0; d = rdata;
    endtask

    task automatic ticks(int n);
        @(negedge clk); tick_en = 1;
        repeat (n) @(negedge clk);
        tick_en = 0;
    endtask

    task automatic t_reset();
        rd(0, v); chk("R1 ctrl", v, 32'h0);
        rd(1, v); chk("R1 count", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        ticks(3);
        rd(1, v); chk("R1 idle count", v, 32'h0);
    endtask

    task automatic t_count();
        wr(1, 32'hABCD0000);
        rd(1, v); chk("R2 readback", v, 32'hABCD0000);
        wr(0, 32'hC0FFFFFF);
        ticks(5);
        rd(1, v); chk("R2 increments", v, 32'hABCD0005);
        repeat (4) @(negedge clk);
        rd(1, v); chk("R2 hold", v, 32'hABCD0005);
        rd(0, v); chk("R2 ctrl read", v, 32'hC0FFFFFF);
    endtask

    task automatic t_wrap();
        wr(0, 32'hE0000001);
        wr(1, 32'h0FFFFFFE);
        ticks(2);
        chk("R4 no early match", {31'b0, irq}, 32'h0);
        rd(1, v); chk("R3 upper bits count", v, 32'h10000000);
        ticks(1);
        chk("R4 match after wrap", {31'b0, irq}, 32'h1);
        rd(0, v); chk("R5 pending set", v, 32'hF0000001);
        rd(1, v); chk("R9 continuous", v, 32'h10000001);
    endtask

    task automatic t_noie();
        wr(0, 32'hC0000003);
        wr(1, 32'h0);
        ticks(3);
        rd(0, v); chk("R5 no enable no pending", v, 32'hC0000003);
        chk("R5 irq low", {31'b0, irq}, 32'h0);
        ticks(2);
        rd(1, v); chk("R9 keeps counting", v, 32'h5);
    endtask

    task automatic t_clear();
        wr(0, 32'hE0000005);
        wr(1, 32'h4);
        ticks(1);
        chk("R5 irq high", {31'b0, irq}, 32'h1);
        wr(0, 32'hE0000005);
        chk("R6 cleared", {31'b0, irq}, 32'h0);
        wr(1, 32'h4);
        @(negedge clk); sel = 1; we = 1; addr = 0; wdata = 32'hE0000005; tick_en = 1;
        @(negedge clk); sel = 0; we = 0; tick_en = 0;
        chk("R6 match beats clear", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_restart();
        wr(0, 32'h40000004);
        wr(1, 32'h0);
        ticks(3);
        rd(1, v); chk("R7 before match", v, 32'h3);
        ticks(1);
        rd(1, v); chk("R7 cleared", v, 32'h0);
        ticks(2);
        rd(1, v); chk("R7 continues", v, 32'h2);
    endtask

    task automatic t_single();
        wr(0, 32'hA0000003);
        wr(1, 32'h0);
        ticks(3);
        chk("R8 irq", {31'b0, irq}, 32'h1);
        ticks(4);
        rd(1, v); chk("R8 holds", v, 32'h3);
        wr(0, 32'h80000003);
        ticks(2);
        rd(1, v); chk("R8 restarted", v, 32'h5);
    endtask

    task automatic t_off();
        wr(0, 32'hC0FFFFFF);
        wr(1, 32'h0);
        ticks(2);
        wr(0, 32'h20000002);
        ticks(5);
        rd(1, v); chk("R10 stopped", v, 32'h2);
        wr(1, 32'h1);
        ticks(5);
        rd(1, v); chk("R10 still stopped", v, 32'h1);
        rd(0, v); chk("R10 no pending", v, 32'h20000002);
    endtask

    task automatic t_wrtick();
        wr(0, 32'hC0FFFFFF);
        wr(1, 32'h0);
        @(negedge clk); sel = 1; we = 1; addr = 1; wdata = 32'h100; tick_en = 1;
        @(negedge clk); sel = 0; we = 0; tick_en = 0;
        rd(1, v); chk("R11 write wins", v, 32'h100);
        ticks(1);
        rd(1, v); chk("R11 then counts", v, 32'h101);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_count();
        t_wrap();
        t_noie();
        t_clear();
        t_restart();
        t_single();
        t_off();
        t_wrtick();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule